// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port that moves one byte at a time over a single bidirectional data line. It always drives the shift clock on a separate line, for transmit and for receive. Each byte goes out or comes in least significant bit first. A speed-select input picks a bit period of 12 or 4 system clocks. Each speed has its own fixed placement of the data ahead of the clock's falling edge and its own clock-low time. As a result, a receiver can capture on the rising edge of the shift clock or while the clock is low.

Software reaches the port through one shared buffer address. A write there loads the transmit shifter and starts a frame at once. A read returns the last byte that was fully received. A receive frame starts on its own when receive is enabled and the receive-done flag is clear. Transmit-done and receive-done flags stay set until software clears them. Their OR forms the interrupt request.

Top module: `sync_shift_port`

## Requirements
- R1: A frame carries 8 bits, least significant bit first, and lasts exactly 8 bit periods from the edge that starts it.
- R2: With `fast_sel` = 0 the bit period is 12 system clocks; with `fast_sel` = 1 it is 4 system clocks.
- R3: Slow setting: each bit is presented at phase 0 of its period, the shift clock falls at phase 3, stays low through phase 8 (six clocks) and is high again from phase 9.
- R4: Fast setting: each bit is presented at phase 0, the shift clock falls at phase 1, stays low for phases 1 and 2 and is high at phase 3.
- R5: While idle or receiving, `sclk_o` is high outside the low windows and `sdat_oe` is 0; `sdat_oe` is 1 only during a transmit frame.
- R6: A `wr_en` pulse while idle starts a transmit on that clock edge. `tx_done` reads 1 exactly 8 bit periods later, in the cycle after the last bit period.
- R7: With `rx_en` = 1, `rx_done` = 0, the port idle and no write pending, a receive frame starts. `sdat_i` is sampled just before each rising edge of `sclk_o`. At the end of the frame the byte appears on `rd_data` and `rx_done` is set.
- R8: A `wr_en` pulse during an active frame is ignored: the bits already being sent and the frame length are unchanged.
- R9: `tx_done` and `rx_done` stay 1 until their clear strobe (a set on the same edge wins). `irq` is 1 whenever either flag is 1.
- R10: The speed setting is captured at the start of a frame; changing `fast_sel` mid-frame does not alter the current frame's timing.
- R11: `rd_data` holds the last completed receive byte and is changed by nothing else, including transmits. While `rx_done` = 1, no new receive frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe to the shared buffer address |
| wr_data | input | 8 | Byte written to the transmit shifter |
| rd_data | output | 8 | Last completed receive byte |
| fast_sel | input | 1 | Speed select: 0 = 12-clock bit, 1 = 4-clock bit |
| rx_en | input | 1 | Receive enable |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| sdat_i | input | 1 | Data line input |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| sclk_o | output | 1 | Shift clock, idles high |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| irq | output | 1 | Interrupt request, OR of both flags |

## Verification
The assertions take for granted that the flag clear strobes are single-cycle pulses driven by software. They also assume `sdat_i` is held steady across the sampling edge inside each clock-low window. The bench changes `sdat_i` only on falling system-clock edges, and only to the bit of the current period. It raises `wr_en` and the clear strobes for exactly one cycle each. A write or a speed change during a frame is driven only from the bench's directed cases, so the properties on data stability and held speed see the stimulus they expect.

// File: rtl/sp_pkg.sv
package sp_pkg;
   function automatic int sp_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int sp_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/sp_timebase.sv
module sp_timebase
   import sp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SLOW_P    = 12,
   parameter int SLOW_LEAD = 3,
   parameter int SLOW_LOW  = 6,
   parameter int FAST_P    = 4,
   parameter int FAST_LEAD = 1,
   parameter int FAST_LOW  = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fast_req,
   output logic active,
   output logic spd_q,
   output logic bit_end,
   output logic frame_end,
   output logic clk_low,
   output logic rise_stb
);
   localparam int MAX_P = sp_max(SLOW_P, FAST_P);
   localparam int PH_W  = sp_bits(MAX_P);
   localparam int BC_W  = sp_bits(DATA_W);
   localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

   logic [PH_W-1:0] ph;
   logic [BC_W-1:0] bc;
   logic [PH_W-1:0] lim_a  [2];
   logic [PH_W-1:0] fall_a [2];
   logic [PH_W-1:0] rise_a [2];

   generate
      for (genvar s = 0; s < 2; s++) begin : g_spd
         localparam int P    = (s == 1) ? FAST_P    : SLOW_P;
         localparam int LEAD = (s == 1) ? FAST_LEAD : SLOW_LEAD;
         localparam int LOW  = (s == 1) ? FAST_LOW  : SLOW_LOW;
         if (LEAD < 1 || LOW < 1 || LEAD + LOW >= P) begin : g_bad
            $error("sp_timebase: lead plus low time must fit inside the bit period");
         end
         assign lim_a[s]  = PH_W'(P - 1);
         assign fall_a[s] = PH_W'(LEAD);
         assign rise_a[s] = PH_W'(LEAD + LOW);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         spd_q  <= 1'b0;
         ph     <= '0;
         bc     <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            spd_q  <= fast_req;
            ph     <= '0;
            bc     <= '0;
         end
      end else if (bit_end) begin
         ph <= '0;
         if (bc == LAST_BIT) active <= 1'b0;
         else                bc     <= bc + 1'b1;
      end else begin
         ph <= ph + 1'b1;
      end
   end

   assign bit_end   = active && (ph == lim_a[spd_q]);
   assign frame_end = bit_end && (bc == LAST_BIT);
   assign clk_low   = active && (ph >= fall_a[spd_q]) && (ph < rise_a[spd_q]);
   assign rise_stb  = active && (ph == rise_a[spd_q] - 1'b1);
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_tx,
   input  logic              start_rx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              bit_end,
   input  logic              rise_stb,
   input  logic              frame_end,
   input  logic              sdat_i,
   output logic              tx_mode,
   output logic              sdat_o,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_commit
);
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_mode <= 1'b0;
         tx_q    <= '0;
         rx_q    <= '0;
         rd_data <= '0;
      end else begin
         if (load_tx) begin
            tx_mode <= 1'b1;
            tx_q    <= wdata;
         end else if (start_rx) begin
            tx_mode <= 1'b0;
         end else if (tx_mode && bit_end) begin
            tx_q <= {1'b1, tx_q[DATA_W-1:1]};
         end
         if (!tx_mode && rise_stb)
            rx_q <= {sdat_i, rx_q[DATA_W-1:1]};
         if (rx_commit)
            rd_data <= rx_q;
      end
   end

   assign sdat_o    = tx_q[0];
   assign rx_commit = frame_end && !tx_mode;
endmodule

// File: rtl/sp_flags.sv
module sp_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_tx,
   input  logic set_rx,
   input  logic clr_tx,
   input  logic clr_rx,
   output logic tx_done,
   output logic rx_done
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_done <= 1'b0;
         rx_done <= 1'b0;
      end else begin
         if (set_tx)      tx_done <= 1'b1;
         else if (clr_tx) tx_done <= 1'b0;
         if (set_rx)      rx_done <= 1'b1;
         else if (clr_rx) rx_done <= 1'b0;
      end
   end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
   parameter int DATA_W    = 8,
   parameter int SLOW_P    = 12,
   parameter int SLOW_LEAD = 3,
   parameter int SLOW_LOW  = 6,
   parameter int FAST_P    = 4,
   parameter int FAST_LEAD = 1,
   parameter int FAST_LOW  = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              fast_sel,
   input  logic              rx_en,
   input  logic              clr_tx_done,
   input  logic              clr_rx_done,
   input  logic              sdat_i,
   output logic              sdat_o,
   output logic              sdat_oe,
   output logic              sclk_o,
   output logic              tx_done,
   output logic              rx_done,
   output logic              irq
);
   if (DATA_W < 2) begin : g_bad_w
      $error("sync_shift_port: DATA_W must be at least 2");
   end

   logic active, spd_q, bit_end, frame_end, clk_low, rise_stb;
   logic tx_mode, rx_commit, start_tx, start_rx;

   assign start_tx = wr_en && !active;
   assign start_rx = rx_en && !rx_done && !active && !wr_en;

   sp_timebase #(
      .DATA_W(DATA_W), .SLOW_P(SLOW_P), .SLOW_LEAD(SLOW_LEAD), .SLOW_LOW(SLOW_LOW),
      .FAST_P(FAST_P), .FAST_LEAD(FAST_LEAD), .FAST_LOW(FAST_LOW)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .start(start_tx || start_rx), .fast_req(fast_sel),
      .active(active), .spd_q(spd_q), .bit_end(bit_end), .frame_end(frame_end),
      .clk_low(clk_low), .rise_stb(rise_stb)
   );

   sp_shifter #(.DATA_W(DATA_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .load_tx(start_tx), .start_rx(start_rx),
      .wdata(wr_data), .bit_end(bit_end), .rise_stb(rise_stb), .frame_end(frame_end),
      .sdat_i(sdat_i), .tx_mode(tx_mode), .sdat_o(sdat_o), .rd_data(rd_data),
      .rx_commit(rx_commit)
   );

   sp_flags u_fl (
      .clk(clk), .rst_n(rst_n), .set_tx(frame_end && tx_mode), .set_rx(rx_commit),
      .clr_tx(clr_tx_done), .clr_rx(clr_rx_done), .tx_done(tx_done), .rx_done(rx_done)
   );

   assign sclk_o  = !clk_low;
   assign sdat_oe = active && tx_mode;
   assign irq     = tx_done || rx_done;
endmodule

// File: rtl/sp_check.sv
module sp_check #(
   parameter int DATA_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              active,
   input logic              tx_mode,
   input logic              spd_q,
   input logic              rx_commit,
   input logic              sclk_o,
   input logic              sdat_o,
   input logic              sdat_oe,
   input logic              tx_done,
   input logic              rx_done,
   input logic              clr_tx_done,
   input logic              clr_rx_done,
   input logic [DATA_W-1:0] rd_data
);
   a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (sclk_o && !sdat_oe));

   a_r5_oe_only_tx: assert property (@(posedge clk) disable iff (!rst_n)
      sdat_oe |-> tx_mode);

   a_r3_data_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sdat_oe && !sclk_o && !$past(sclk_o)) |-> $stable(sdat_o));

   a_r9_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !clr_tx_done) |=> tx_done);

   a_r9_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !clr_rx_done) |=> rx_done);

   a_r10_speed_held: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(spd_q));

   a_r11_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_commit |=> $stable(rd_data));
endmodule

bind sync_shift_port sp_check #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .active(active), .tx_mode(tx_mode), .spd_q(spd_q),
   .rx_commit(rx_commit), .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
   .tx_done(tx_done), .rx_done(rx_done), .clr_tx_done(clr_tx_done),
   .clr_rx_done(clr_rx_done), .rd_data(rd_data)
);

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       fast_sel = 1'b0;
   logic       rx_en = 1'b0;
   logic       clr_tx_done = 1'b0;
   logic       clr_rx_done = 1'b0;
   logic       sdat_i = 1'b1;
   logic       sdat_o, sdat_oe, sclk_o, tx_done, rx_done, irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   sync_shift_port uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .fast_sel(fast_sel), .rx_en(rx_en), .clr_tx_done(clr_tx_done),
      .clr_rx_done(clr_rx_done), .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
      .sclk_o(sclk_o), .tx_done(tx_done), .rx_done(rx_done), .irq(irq)
   );

   // {fast, tx byte, rx byte}
   localparam logic [16:0] VEC [6] = '{
      {1'b0, 8'hA5, 8'h3C}, {1'b1, 8'h5A, 8'hC3}, {1'b0, 8'h01, 8'h80},
      {1'b1, 8'h80, 8'h01}, {1'b1, 8'hFF, 8'h00}, {1'b0, 8'h00, 8'hFF}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int per(input bit f);  return f ? 4 : 12; endfunction
   function automatic int lead(input bit f); return f ? 1 : 3;  endfunction
   function automatic int lowt(input bit f); return f ? 2 : 6;  endfunction

   task automatic pulse_clear(input bit t, input bit r);
      @(negedge clk);
      clr_tx_done = t;
      clr_rx_done = r;
      @(negedge clk);
      clr_tx_done = 1'b0;
      clr_rx_done = 1'b0;
   endtask

   // transmit one byte; disturb writes another byte and flips speed mid-frame
   task automatic run_tx(input bit f, input logic [7:0] b, input bit disturb);
      int         p = per(f);
      int         bad_clk = 0;
      int         bad_oe = 0;
      int         early = 0;
      logic [7:0] got = '0;
      logic [7:0] rd_before = rd_data;
      @(negedge clk);
      fast_sel = f;
      wr_data  = b;
      wr_en    = 1'b1;
      @(posedge clk);
      for (int k = 0; k < 8 * p; k++) begin
         @(negedge clk);
         wr_en = 1'b0;
         fast_sel = f;
         begin
            bit exp_low = ((k % p) >= lead(f)) && ((k % p) < lead(f) + lowt(f));
            if (sclk_o !== !exp_low) bad_clk++;
         end
         if (sdat_oe !== 1'b1) bad_oe++;
         if (tx_done !== 1'b0) early++;
         if ((k % p) == lead(f)) got[k / p] = sdat_o;
         if (disturb && k == p + 2) begin
            wr_data  = ~b;
            wr_en    = 1'b1;
            fast_sel = !f;
         end
      end
      @(negedge clk);
      chk(got == b, disturb ? "R8 R1 bits after mid-frame write" : "R1 tx bits LSB first", got, b);
      chk(bad_clk == 0, f ? "R4 fast clock phasing" : "R3 slow clock phasing", bad_clk, 0);
      chk(bad_oe == 0, "R5 oe during transmit", bad_oe, 0);
      chk(early == 0 && tx_done == 1'b1,
          disturb ? "R10 R6 frame length with speed flip" : "R6 R2 tx_done timing",
          {early[15:0], 15'b0, tx_done}, 1);
      chk(sclk_o && !sdat_oe, "R5 idle after transmit", {sclk_o, sdat_oe}, 2'b10);
      chk(rd_data == rd_before, "R11 transmit leaves rd_data", rd_data, rd_before);
   endtask

   task automatic run_rx(input bit f, input logic [7:0] b);
      int p = per(f);
      int bad_oe = 0;
      int early = 0;
      @(negedge clk);
      fast_sel = f;
      rx_en    = 1'b1;
      sdat_i   = b[0];
      @(posedge clk);
      for (int k = 0; k < 8 * p; k++) begin
         @(negedge clk);
         if (sdat_oe !== 1'b0) bad_oe++;
         if (rx_done !== 1'b0) early++;
         sdat_i = b[k / p];
      end
      @(negedge clk);
      rx_en = 1'b0;
      chk(bad_oe == 0, "R5 line released while receiving", bad_oe, 0);
      chk(early == 0 && rx_done == 1'b1, "R7 rx_done timing", {early[15:0], 15'b0, rx_done}, 1);
      chk(rd_data == b, "R7 R1 received byte", rd_data, b);
      chk(irq == 1'b1, "R9 irq from rx_done", irq, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk_o == 1'b1 && sdat_oe == 1'b0, "R5 reset idle line", {sclk_o, sdat_oe}, 2'b10);
      chk(tx_done == 0 && rx_done == 0 && irq == 0, "R9 reset flags", {tx_done, rx_done, irq}, 0);
      chk(rd_data == 8'h00, "R11 reset buffer", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 6; i++) begin
         run_tx(VEC[i][16], VEC[i][15:8], 1'b0);
         pulse_clear(1'b1, 1'b0);
         chk(tx_done == 1'b0, "R9 tx clear", tx_done, 0);
         run_rx(VEC[i][16], VEC[i][7:0]);
         pulse_clear(1'b0, 1'b1);
         chk(rx_done == 1'b0 && irq == 1'b0, "R9 rx clear", {rx_done, irq}, 0);
      end

      // R8 / R10: mid-frame write and speed flip, both speeds
      run_tx(1'b0, 8'h96, 1'b1);
      pulse_clear(1'b1, 1'b0);
      run_tx(1'b1, 8'h69, 1'b1);

      // R9: flag holds without a clear, irq follows either flag
      repeat (10) @(negedge clk);
      chk(tx_done == 1'b1 && irq == 1'b1, "R9 tx flag held", {tx_done, irq}, 2'b11);
      run_rx(1'b1, 8'h5C);
      pulse_clear(1'b1, 1'b0);
      chk(tx_done == 0 && rx_done == 1 && irq == 1, "R9 irq with rx only", {tx_done, rx_done, irq}, 3'b011);

      // R11: no new receive while rx_done is set
      begin
         int moved = 0;
         @(negedge clk);
         rx_en  = 1'b1;
         sdat_i = 1'b0;
         repeat (30) begin
            @(negedge clk);
            if (sclk_o !== 1'b1) moved++;
         end
         rx_en = 1'b0;
         chk(moved == 0, "R11 no receive while rx_done set", moved, 0);
         chk(rd_data == 8'h5C, "R11 buffer kept", rd_data, 8'h5C);
      end
      pulse_clear(1'b0, 1'b1);

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule